// File: doc/BRIEF.md
# Shared-Memory FIFO Bus Master

This block lets a host-side controller borrow the memory bus of an 8-bit microprocessor and use the processor's memory as a mailbox. For every command it asks the processor for its bus and waits for the grant. It then runs byte-wide read and write cycles over a 19-bit (512 KiB) address space and hands the bus back. Raw byte reads and writes are available. A separate command pulses the processor's reset line low for a fixed time.

Two single-producer/single-consumer ring FIFOs live in the shared memory. Each FIFO keeps three control bytes just below its buffer base: the size mask, the input index and the output index. The block keeps local shadow copies of its own index and of the mask. For each put or get it reads the index owned by the other side from memory, decides whether there is space or data, and then moves the byte and writes its own index back. All of this happens inside one bus grant. If the FIFO is full (for a put) or empty (for a get), the block releases the bus and tries again until the other side has made progress.

Top module: `shared_bus_fifo_master`

## Requirements
- R1: After reset the bus request, memory request, read strobe, write strobe and processor reset outputs are all high, the address and data drivers are disabled, the command port is ready and no response is pending.
- R2: The block drives `busreq_no` low and enables the address drivers only after it has sampled `busack_ni` low. Memory cycles happen only while the grant is held.
- R3: To release the bus, the block turns off the data drivers, then the address drivers, then raises `busreq_no`. A command that used the bus responds only after `busack_ni` has returned high.
- R4: A write cycle presents the address, then asserts `mreq_no` and drives the data, then pulses `wr_no` low and high, then deasserts `mreq_no`.
- R5: A read cycle turns the data drivers off, asserts `mreq_no`, holds `rd_no` low for exactly two cycles, captures `data_i` and then deasserts `rd_no` and `mreq_no`.
- R6: Command codes on `cmd_op_i` are: 0 init, 1 put, 2 get, 3 raw read, 4 raw write, 5 processor reset. A raw read returns the byte at `cmd_addr_i` on `rsp_data_o`. A raw write stores `cmd_data_i` there.
- R7: Init of FIFO `cmd_sel_i` with base B loads the mask from B−3, the input index from B−2 and the output index from B−1, and records B as the FIFO's base.
- R8: A put writes `cmd_data_i` at base+in first. It then writes the new input index (in+1)&mask to base−2.
- R9: A put on a full FIFO, where (in+1)&mask equals the output index read from base−1, does not respond. It releases and re-requests the bus until space appears, and then completes.
- R10: A get reads the byte at base+out and returns it on `rsp_data_o`. It then writes (out+1)&mask to base−1. Indices wrap through the mask.
- R11: A get on an empty FIFO, where the input index at base−2 equals the local out, retries like R9 until data appears.
- R12: A put or get on a FIFO whose base is zero, and any command code of 6 or 7, responds at once with `rsp_nack_o` high and no bus request.
- R13: The reset command drives `cpu_rst_no` low for exactly CLK_MHZ×RST_US cycles (10 µs by default) and then high, without requesting the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Block idle, command taken this cycle |
| cmd_op_i | input | 3 | Command code (R6) |
| cmd_sel_i | input | SEL_W | FIFO select |
| cmd_addr_i | input | ADDR_W | Raw address or FIFO base |
| cmd_data_i | input | DATA_W | Write or put data |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_nack_o | output | 1 | Command refused (R12) |
| rsp_data_o | output | DATA_W | Read or get data |
| busreq_no | output | 1 | Bus request, active low |
| busack_ni | input | 1 | Bus grant, active low |
| mreq_no | output | 1 | Memory request, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| cpu_rst_no | output | 1 | Processor reset, active low |
| addr_o | output | ADDR_W | Address bus value |
| addr_oe_o | output | 1 | Address driver enable |
| data_o | output | DATA_W | Data bus value driven |
| data_oe_o | output | 1 | Data driver enable |
| data_i | input | DATA_W | Data bus value sampled |

## Verification
Puts are sent into a FIFO that starts mid-ring. They run until the index wraps from the top slot to zero and the ring fills, which separates the correct mask arithmetic from off-by-one full detection. A put held off by a full ring and a get held off by an empty ring are each released by the processor side changing the other index in memory. This shows that the block reads that index again on every attempt and does not trust a stale copy. Raw accesses, uninitialized FIFOs, unused codes and the reset pulse separate true bus cycles from refused commands, which must leave the bus untouched.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam logic [2:0] OP_INIT    = 3'd0;
  localparam logic [2:0] OP_PUT     = 3'd1;
  localparam logic [2:0] OP_GET     = 3'd2;
  localparam logic [2:0] OP_READ    = 3'd3;
  localparam logic [2:0] OP_WRITE   = 3'd4;
  localparam logic [2:0] OP_CPU_RST = 3'd5;

  typedef enum logic [1:0] {XK_ACQ, XK_REL, XK_RD, XK_WR} xfer_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ACQ, S_RD0, S_RD1, S_RD2, S_DEC, S_WR0, S_WR1, S_REL, S_PULSE
  } seq_e;
endpackage

// File: rtl/bus_xfer_engine.sv
module bus_xfer_engine
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  xfer_e             kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busreq_no,
  input  logic              busack_ni,
  output logic              mreq_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [DATA_W-1:0] data_i
);
  localparam logic [2:0] ST_DONE = 3'd7;

  logic [2:0]        st_q;
  xfer_e             kind_q;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] w_q;

  assign done_o = (st_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= '0;
      kind_q    <= XK_ACQ;
      a_q       <= '0;
      w_q       <= '0;
      rdata_o   <= '0;
      busreq_no <= 1'b1;
      mreq_no   <= 1'b1;
      rd_no     <= 1'b1;
      wr_no     <= 1'b1;
      addr_o    <= '0;
      addr_oe_o <= 1'b0;
      data_o    <= '0;
      data_oe_o <= 1'b0;
    end else if (st_q == 3'd0) begin
      if (req_i) begin
        st_q   <= 3'd1;
        kind_q <= kind_i;
        a_q    <= addr_i;
        w_q    <= wdata_i;
      end
    end else if (st_q == ST_DONE) begin
      st_q <= '0;
    end else begin
      unique case (kind_q)
        XK_ACQ: begin
          if (st_q == 3'd1) begin
            busreq_no <= 1'b0;
            st_q      <= 3'd2;
          end else if (!busack_ni) begin
            addr_oe_o <= 1'b1;
            st_q      <= ST_DONE;
          end
        end
        XK_REL: begin
          case (st_q)
            3'd1:    begin data_oe_o <= 1'b0; st_q <= 3'd2; end
            3'd2:    begin addr_oe_o <= 1'b0; st_q <= 3'd3; end
            3'd3:    begin busreq_no <= 1'b1; st_q <= 3'd4; end
            default: if (busack_ni) st_q <= ST_DONE;
          endcase
        end
        XK_WR: begin
          case (st_q)
            3'd1: begin addr_o <= a_q; st_q <= 3'd2; end
            3'd2: begin
              mreq_no   <= 1'b0;
              data_o    <= w_q;
              data_oe_o <= 1'b1;
              st_q      <= 3'd3;
            end
            3'd3:    begin wr_no <= 1'b0; st_q <= 3'd4; end
            3'd4:    begin wr_no <= 1'b1; st_q <= 3'd5; end
            default: begin mreq_no <= 1'b1; st_q <= ST_DONE; end
          endcase
        end
        XK_RD: begin
          case (st_q)
            3'd1: begin addr_o <= a_q; data_oe_o <= 1'b0; st_q <= 3'd2; end
            3'd2: begin mreq_no <= 1'b0; st_q <= 3'd3; end
            3'd3: begin rd_no <= 1'b0; st_q <= 3'd4; end
            3'd4: st_q <= 3'd5;
            default: begin
              rdata_o <= data_i;
              rd_no   <= 1'b1;
              mreq_no <= 1'b1;
              st_q    <= ST_DONE;
            end
          endcase
        end
        default: st_q <= ST_DONE;
      endcase
    end
  end
endmodule

// File: rtl/fifo_shadow_regs.sv
module fifo_shadow_regs #(
  parameter int NUM_FIFOS = 2,
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int SEL_W     = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              init_we_i,
  input  logic [ADDR_W-1:0] init_base_i,
  input  logic [DATA_W-1:0] init_mask_i,
  input  logic [DATA_W-1:0] init_in_i,
  input  logic [DATA_W-1:0] init_out_i,
  input  logic              in_we_i,
  input  logic              out_we_i,
  input  logic [DATA_W-1:0] idx_next_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] in_o,
  output logic [DATA_W-1:0] out_o
);
  logic [NUM_FIFOS-1:0][ADDR_W-1:0] base_all;
  logic [NUM_FIFOS-1:0][DATA_W-1:0] mask_all, in_all, out_all;

  for (genvar g = 0; g < NUM_FIFOS; g++) begin : g_fifo
    logic [ADDR_W-1:0] base_q;
    logic [DATA_W-1:0] mask_q, in_q, out_q;
    logic hit;
    assign hit = (sel_i == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q <= '0;
        mask_q <= '0;
        in_q   <= '0;
        out_q  <= '0;
      end else if (hit) begin
        if (init_we_i) begin
          base_q <= init_base_i;
          mask_q <= init_mask_i;
          in_q   <= init_in_i;
          out_q  <= init_out_i;
        end else begin
          if (in_we_i)  in_q  <= idx_next_i;
          if (out_we_i) out_q <= idx_next_i;
        end
      end
    end

    assign base_all[g] = base_q;
    assign mask_all[g] = mask_q;
    assign in_all[g]   = in_q;
    assign out_all[g]  = out_q;
  end

  assign base_o = base_all[sel_i];
  assign mask_o = mask_all[sel_i];
  assign in_o   = in_all[sel_i];
  assign out_o  = out_all[sel_i];
endmodule

// File: rtl/cpu_reset_pulser.sv
module cpu_reset_pulser #(
  parameter int CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic cpu_rst_no,
  output logic done_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      cpu_rst_no <= 1'b1;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && cpu_rst_no) begin
        cpu_rst_no <= 1'b0;
        cnt_q      <= CNT_W'(CYCLES - 1);
      end else if (!cpu_rst_no) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else begin
          cpu_rst_no <= 1'b1;
          done_o     <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/shared_bus_fifo_master.sv
module shared_bus_fifo_master
  import sbm_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int NUM_FIFOS = 2,
  parameter int CLK_MHZ   = 100,
  parameter int RST_US    = 10,
  localparam int SEL_W    = (NUM_FIFOS > 1) ? $clog2(NUM_FIFOS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [2:0]        cmd_op_i,
  input  logic [SEL_W-1:0]  cmd_sel_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_nack_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              busreq_no,
  input  logic              busack_ni,
  output logic              mreq_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic              cpu_rst_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [DATA_W-1:0] data_i
);
  localparam int RST_CYCLES = CLK_MHZ * RST_US;
  localparam int PAD_W      = ADDR_W - DATA_W;

  seq_e              state_q;
  logic [2:0]        op_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, ra_q, rb_q, rc_q;
  logic              retry_q, rsp_valid_q, rsp_nack_q;

  logic              x_req, x_done;
  xfer_e             x_kind;
  logic [ADDR_W-1:0] x_addr;
  logic [DATA_W-1:0] x_wdata, x_rdata;

  logic [SEL_W-1:0]  sh_sel;
  logic [ADDR_W-1:0] base_s, fbase;
  logic [DATA_W-1:0] mask_s, in_s, out_s, idx_cur, idx_nxt;
  logic              init_we, in_we, out_we;
  logic              pulse_start, pulse_done;

  assign cmd_ready_o = (state_q == S_IDLE);
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_nack_o  = rsp_nack_q;
  assign rsp_data_o  = rb_q;

  assign sh_sel  = (state_q == S_IDLE) ? cmd_sel_i : sel_q;
  assign fbase   = (op_q == OP_INIT) ? addr_q : base_s;
  assign idx_cur = (op_q == OP_PUT) ? in_s : out_s;
  assign idx_nxt = (idx_cur + 1'b1) & mask_s;

  assign init_we = (state_q == S_REL) && x_done && !retry_q && (op_q == OP_INIT);
  assign in_we   = (state_q == S_WR1) && x_done && (op_q == OP_PUT);
  assign out_we  = (state_q == S_WR1) && x_done && (op_q == OP_GET);

  assign pulse_start = (state_q == S_IDLE) && cmd_valid_i && (cmd_op_i == OP_CPU_RST);

  always_comb begin
    x_req   = 1'b1;
    x_kind  = XK_RD;
    x_addr  = addr_q;
    x_wdata = wdata_q;
    unique case (state_q)
      S_ACQ: x_kind = XK_ACQ;
      S_REL: x_kind = XK_REL;
      S_RD0: x_addr = (op_q == OP_INIT) ? fbase - ADDR_W'(3) :
                      (op_q == OP_PUT)  ? fbase - ADDR_W'(1) : fbase - ADDR_W'(2);
      S_RD1: x_addr = (op_q == OP_INIT) ? fbase - ADDR_W'(2) :
                      (op_q == OP_GET)  ? fbase + {{PAD_W{1'b0}}, out_s} : addr_q;
      S_RD2: x_addr = fbase - ADDR_W'(1);
      S_WR0: begin
        x_kind = XK_WR;
        x_addr = (op_q == OP_PUT) ? fbase + {{PAD_W{1'b0}}, in_s} : addr_q;
      end
      S_WR1: begin
        x_kind  = XK_WR;
        x_addr  = (op_q == OP_PUT) ? fbase - ADDR_W'(2) : fbase - ADDR_W'(1);
        x_wdata = idx_nxt;
      end
      default: x_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      op_q        <= OP_INIT;
      sel_q       <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      ra_q        <= '0;
      rb_q        <= '0;
      rc_q        <= '0;
      retry_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_nack_q  <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (cmd_valid_i) begin
          op_q    <= cmd_op_i;
          sel_q   <= cmd_sel_i;
          addr_q  <= cmd_addr_i;
          wdata_q <= cmd_data_i;
          if ((cmd_op_i > OP_CPU_RST) ||
              (((cmd_op_i == OP_PUT) || (cmd_op_i == OP_GET)) && (base_s == '0))) begin
            rsp_valid_q <= 1'b1;
            rsp_nack_q  <= 1'b1;
          end else if (cmd_op_i == OP_CPU_RST) begin
            state_q <= S_PULSE;
          end else begin
            state_q <= S_ACQ;
          end
        end
        S_PULSE: if (pulse_done) begin
          rsp_valid_q <= 1'b1;
          rsp_nack_q  <= 1'b0;
          state_q     <= S_IDLE;
        end
        S_ACQ: if (x_done) begin
          state_q <= (op_q == OP_READ) ? S_RD1 : (op_q == OP_WRITE) ? S_WR0 : S_RD0;
        end
        S_RD0: if (x_done) begin
          ra_q    <= x_rdata;
          state_q <= (op_q == OP_INIT) ? S_RD1 : S_DEC;
        end
        S_DEC: begin
          // Put: full when the advanced in-index meets memory's out-index.
          // Get: empty when memory's in-index equals local out.
          if ((op_q == OP_PUT) ? (idx_nxt == ra_q) : (ra_q == out_s)) begin
            retry_q <= 1'b1;
            state_q <= S_REL;
          end else begin
            state_q <= (op_q == OP_PUT) ? S_WR0 : S_RD1;
          end
        end
        S_RD1: if (x_done) begin
          rb_q    <= x_rdata;
          state_q <= (op_q == OP_INIT) ? S_RD2 : (op_q == OP_GET) ? S_WR1 : S_REL;
        end
        S_RD2: if (x_done) begin
          rc_q    <= x_rdata;
          state_q <= S_REL;
        end
        S_WR0: if (x_done) state_q <= (op_q == OP_PUT) ? S_WR1 : S_REL;
        S_WR1: if (x_done) state_q <= S_REL;
        S_REL: if (x_done) begin
          if (retry_q) begin
            retry_q <= 1'b0;
            state_q <= S_ACQ;
          end else begin
            rsp_valid_q <= 1'b1;
            rsp_nack_q  <= 1'b0;
            state_q     <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  bus_xfer_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
    .clk_i, .rst_ni,
    .req_i(x_req), .kind_i(x_kind), .addr_i(x_addr), .wdata_i(x_wdata),
    .done_o(x_done), .rdata_o(x_rdata),
    .busreq_no, .busack_ni, .mreq_no, .rd_no, .wr_no,
    .addr_o, .addr_oe_o, .data_o, .data_oe_o, .data_i
  );

  fifo_shadow_regs #(
    .NUM_FIFOS(NUM_FIFOS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
  ) u_shadow (
    .clk_i, .rst_ni,
    .sel_i(sh_sel), .init_we_i(init_we), .init_base_i(addr_q),
    .init_mask_i(ra_q), .init_in_i(rb_q), .init_out_i(rc_q),
    .in_we_i(in_we), .out_we_i(out_we), .idx_next_i(idx_nxt),
    .base_o(base_s), .mask_o(mask_s), .in_o(in_s), .out_o(out_s)
  );

  cpu_reset_pulser #(.CYCLES(RST_CYCLES)) u_rst_pulse (
    .clk_i, .rst_ni, .start_i(pulse_start),
    .cpu_rst_no, .done_o(pulse_done)
  );
endmodule

// File: rtl/shared_bus_fifo_master_chk.sv
module shared_bus_fifo_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busreq_no,
  input logic busack_ni,
  input logic mreq_no,
  input logic rd_no,
  input logic wr_no,
  input logic cpu_rst_no,
  input logic addr_oe_o,
  input logic data_oe_o,
  input logic rsp_valid_o,
  input logic cmd_ready_o
);
  // R2
  addr_drive_granted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_oe_o |-> !busack_ni);
  // R2
  mreq_needs_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mreq_no |-> addr_oe_o);
  // R3
  release_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busreq_no) |-> (!addr_oe_o && !data_oe_o));
  // R3
  data_off_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(addr_oe_o) |-> !data_oe_o);
  // R4
  wr_strobe_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_no) |-> (!mreq_no && data_oe_o));
  // R4
  mreq_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mreq_no) |-> (rd_no && wr_no));
  // R5
  rd_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_no) |=> !rd_no);
  // R5
  rd_bus_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> (!mreq_no && !data_oe_o));
  // R6
  rsp_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> cmd_ready_o);
  // R13
  pulse_no_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_rst_no |-> busreq_no);
endmodule

bind shared_bus_fifo_master shared_bus_fifo_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busreq_no(busreq_no), .busack_ni(busack_ni),
  .mreq_no(mreq_no), .rd_no(rd_no), .wr_no(wr_no), .cpu_rst_no(cpu_rst_no),
  .addr_oe_o(addr_oe_o), .data_oe_o(data_oe_o),
  .rsp_valid_o(rsp_valid_o), .cmd_ready_o(cmd_ready_o)
);

// File: tb/shared_bus_fifo_master_test.sv
module shared_bus_fifo_master_test;
  localparam int RST_CYC = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [0:0]  cmd_sel = '0;
  logic [18:0] cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic        rsp_valid, rsp_nack;
  logic [7:0]  rsp_data;
  logic        busreq_n, busack_n, mreq_n, rd_n, wr_n, cpu_rst_n;
  logic [18:0] addr;
  logic        addr_oe, data_oe;
  logic [7:0]  dout, din;

  shared_bus_fifo_master uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_sel_i(cmd_sel), .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data),
    .rsp_valid_o(rsp_valid), .rsp_nack_o(rsp_nack), .rsp_data_o(rsp_data),
    .busreq_no(busreq_n), .busack_ni(busack_n), .mreq_no(mreq_n),
    .rd_no(rd_n), .wr_no(wr_n), .cpu_rst_no(cpu_rst_n),
    .addr_o(addr), .addr_oe_o(addr_oe), .data_o(dout), .data_oe_o(data_oe),
    .data_i(din)
  );

  // Processor-side memory and grant model
  logic [7:0] mem [int];
  int wlog[$];
  logic [1:0] req_sr;

  function automatic logic [7:0] mrd(int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_sr   <= '0;
      busack_n <= 1'b1;
    end else begin
      req_sr   <= {req_sr[0], ~busreq_n};
      busack_n <= ~(req_sr[1] & req_sr[0] & ~busreq_n);
    end

  always @(posedge clk) din <= mrd(int'(addr));

  always @(posedge wr_n)
    if (mreq_n === 1'b0) begin
      mem[int'(addr)] = dout;
      wlog.push_back(int'(addr));
    end

  int checks = 0, fails = 0;
  int acq_cnt = 0, rst_low = 0, rd_run = 0;

  always @(negedge busreq_n) if (rst_n) acq_cnt++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // Per-clock comparison against the grant and strobe model
  always @(negedge clk)
    if (rst_n) begin
      if (!cpu_rst_n) rst_low++;
      if (!mreq_n) chk_eq("R2 memory cycle while granted", busack_n, 0);
      if (!wr_n) chk_eq("R4 strobe with mreq and data driven", {mreq_n, data_oe}, 2'b01);
      if (!rd_n) begin
        rd_run++;
        chk_eq("R5 data drivers off during read", data_oe, 0);
      end else if (rd_run != 0) begin
        chk_eq("R5 read strobe width", rd_run, 2);
        rd_run = 0;
      end
    end

  task automatic issue(input int op, input int sel, input int a, input int d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op[2:0];
    cmd_sel   = sel[0:0];
    cmd_addr  = a[18:0];
    cmd_data  = d[7:0];
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_rsp(output logic [7:0] data, output bit nack);
    int n = 0;
    while (!rsp_valid && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(rsp_valid, "R6 response arrives", n, 0);
    data = rsp_data;
    nack = rsp_nack;
    if (!nack) chk_eq("R3 bus released at response", {busreq_n, busack_n, addr_oe, data_oe}, 4'b1100);
  endtask

  task automatic run(input int op, input int sel, input int a, input int d,
                     output logic [7:0] data, output bit nack);
    issue(op, sel, a, d);
    wait_rsp(data, nack);
  endtask

  task automatic quiet(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rsp_valid) seen++;
    end
    chk_eq(tag, seen, 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  localparam int B0 = 'h40010;
  localparam int B1 = 'h00100;

  initial begin
    logic [7:0] d;
    bit nk;
    int a0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk_eq("R1 reset outputs", {busreq_n, mreq_n, rd_n, wr_n, cpu_rst_n, addr_oe, data_oe, cmd_ready, rsp_valid},
           9'b111110010);

    // R6 raw read and write; R4 write cycle lands in memory
    mem['h2ABCD] = 8'h3C;
    run(3, 0, 'h2ABCD, 0, d, nk);
    chk_eq("R6 raw read data", d, 'h3C);
    chk_eq("R5 read not refused", nk, 0);
    wlog.delete();
    run(4, 0, 'h12345, 'hA5, d, nk);
    chk_eq("R4 raw write stored", mrd('h12345), 'hA5);
    chk_eq("R6 single write at target", (wlog.size() == 1) ? wlog[0] : -1, 'h12345);

    // R12 uninitialized FIFOs and unused codes
    a0 = acq_cnt;
    run(1, 0, 0, 'h11, d, nk);
    chk_eq("R12 put on zero base refused", nk, 1);
    run(2, 1, 0, 0, d, nk);
    chk_eq("R12 get on zero base refused", nk, 1);
    run(7, 0, 0, 0, d, nk);
    chk_eq("R12 unused code refused", nk, 1);
    chk_eq("R12 no bus request for refused commands", acq_cnt - a0, 0);

    // R7 init of FIFO 0: mask 7, in 2, out 2
    mem[B0-3] = 8'd7; mem[B0-2] = 8'd2; mem[B0-1] = 8'd2;
    run(0, 0, B0, 0, d, nk);
    chk_eq("R7 init accepted", nk, 0);

    // R8 puts through the wrap from slot 7 to slot 0
    for (int k = 0; k < 7; k++) begin
      int idx;
      idx = (2 + k) & 7;
      wlog.delete();
      run(1, 0, 0, 'h20 + k, d, nk);
      chk_eq("R8 put data at base+in", mrd(B0 + idx), 'h20 + k);
      chk_eq("R8 new in index at base-2", mrd(B0 - 2), (idx + 1) & 7);
      chk_eq("R8 data written before index",
             (wlog.size() == 2) ? ((wlog[0] == B0 + idx) && (wlog[1] == B0 - 2)) : 0, 1);
    end

    // R9 full ring retries until the consumer frees a slot
    a0 = acq_cnt;
    issue(1, 0, 0, 'h99);
    quiet(300, "R9 full put holds response");
    chk_eq("R9 command still busy", cmd_ready, 0);
    chk(acq_cnt - a0 > 2, "R9 bus released and re-requested", acq_cnt - a0, 3);
    mem[B0-1] = 8'd3;
    wait_rsp(d, nk);
    chk_eq("R9 put after space at slot 1", mrd(B0 + 1), 'h99);
    chk_eq("R9 in index after retry", mrd(B0 - 2), 2);

    // R11 / R10 FIFO 1: mask 3, in 1, out 1 (empty)
    mem[B1-3] = 8'd3; mem[B1-2] = 8'd1; mem[B1-1] = 8'd1;
    run(0, 1, B1, 0, d, nk);
    issue(2, 1, 0, 0);
    quiet(300, "R11 empty get holds response");
    mem[B1+1] = 8'h5A; mem[B1+2] = 8'h6B; mem[B1-2] = 8'd3;
    wait_rsp(d, nk);
    chk_eq("R11 get after data appears", d, 'h5A);
    chk_eq("R10 out index after get", mrd(B1 - 1), 2);
    run(2, 1, 0, 0, d, nk);
    chk_eq("R10 second get data", d, 'h6B);
    chk_eq("R10 out index 3", mrd(B1 - 1), 3);
    mem[B1+3] = 8'h7C; mem[B1+0] = 8'h8D; mem[B1-2] = 8'd1;
    run(2, 1, 0, 0, d, nk);
    chk_eq("R10 get from top slot", d, 'h7C);
    chk_eq("R10 out index wraps to 0", mrd(B1 - 1), 0);
    run(2, 1, 0, 0, d, nk);
    chk_eq("R10 get after wrap", d, 'h8D);
    chk_eq("R10 out index 1", mrd(B1 - 1), 1);
    chk_eq("R10 FIFO 0 in index untouched", mrd(B0 - 2), 2);

    // R13 processor reset pulse
    a0 = acq_cnt;
    rst_low = 0;
    run(5, 0, 0, 0, d, nk);
    chk_eq("R13 reset low cycles", rst_low, RST_CYC);
    chk_eq("R13 reset released", cpu_rst_n, 1);
    chk_eq("R13 no bus request", acq_cnt - a0, 0);

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule